// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block moves a small data word by exactly one bit position, either towards the most significant end or towards the least significant end. Two control inputs choose the operation: one decides whether the vacated end is filled with zero (a logical shift) or with the bit pushed out of the other end (a rotate), and the other decides the direction. The result appears on the output as a pure function of the present inputs, with no clock, no storage and no latency.

Internally the unit is a single layer of 2-to-1 multiplexers. Two fill multiplexers produce the bit entering at each end, zero for a shift or the wrapped bit for a rotate. One lane multiplexer per output bit then takes either its lower neighbour (left move) or its upper neighbour (right move). For the default width of four bits this comes to six multiplexers. It is meant for datapaths that need a cheap one-place move inside a single combinational stage.

Top module: `shrot_unit`

## Requirements
- R1: With rot_sel = 0 and dir_sel = 0 (shift left), y_out equals a_in moved one place towards the MSB, with bit 0 forced to 0; for four bits, y_out = {a_in[2], a_in[1], a_in[0], 0}.
- R2: With rot_sel = 0 and dir_sel = 1 (shift right), y_out equals a_in moved one place towards the LSB, with the MSB forced to 0; for four bits, y_out = {0, a_in[3], a_in[2], a_in[1]}.
- R3: With rot_sel = 1 and dir_sel = 0 (rotate left), the old MSB enters at bit 0; for four bits, y_out = {a_in[2], a_in[1], a_in[0], a_in[3]}.
- R4: With rot_sel = 1 and dir_sel = 1 (rotate right), the old LSB enters at the MSB; for four bits, y_out = {a_in[0], a_in[3], a_in[2], a_in[1]}.
- R5: A rotate never changes the number of set bits in the word.
- R6: A shift drops the one bit leaving the word: the number of set bits in y_out equals that of a_in minus the departing bit (a_in MSB for a left shift, a_in LSB for a right shift).
- R7: The output is combinational: a change on a_in, rot_sel or dir_sel is visible on y_out without any clock edge, and no earlier input value affects it.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH (4) | Data word to be moved |
| rot_sel | input | 1 | 0 = shift with zero fill, 1 = rotate |
| dir_sel | input | 1 | 0 = towards MSB (left), 1 = towards LSB (right) |
| y_out | output | WIDTH (4) | Moved data word |

## Verification
Since the block holds no state, a fault in it is a wrong multiplexer select or a wrong neighbour wire, and it shows on y_out in the same evaluation as the input that exposes it, with no cycles of delay. A swapped fill select shows up as a stray one or a missing wrapped bit only at the word ends, so the bench drives every data word under every control pair and also checks the set-bit count for rotates and shifts. A fault that makes the output depend on the previous input is caught by changing the inputs between clock edges and sampling before the next edge.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  // Operation code formed as {rot_sel, dir_sel}
  typedef enum logic [1:0] {
    MOVE_SHL = 2'b00,
    MOVE_SHR = 2'b01,
    MOVE_ROL = 2'b10,
    MOVE_ROR = 2'b11
  } move_e;

  function automatic move_e decode_move(input logic rot, input logic dir);
    return move_e'({rot, dir});
  endfunction

endpackage

// File: rtl/shrot_mux2.sv
module shrot_mux2 (
  input  logic d0,
  input  logic d1,
  input  logic sel,
  output logic y
);
  assign y = sel ? d1 : d0;
endmodule

// File: rtl/shrot_fill.sv
// Picks the bits entering each end of the word: zero for a shift,
// the bit leaving the opposite end for a rotate.
module shrot_fill #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic             rot,
  output logic             fill_lo,   // enters bit 0 on a left move
  output logic             fill_hi    // enters the MSB on a right move
);
  localparam int MSB = WIDTH - 1;

  shrot_mux2 u_fill_lo (.d0(1'b0), .d1(a[MSB]), .sel(rot), .y(fill_lo));
  shrot_mux2 u_fill_hi (.d0(1'b0), .d1(a[0]),   .sel(rot), .y(fill_hi));

  always_comb begin
    if (!rot) begin
      assert_shift_fills_zero_R6: assert (fill_lo == 1'b0 && fill_hi == 1'b0)
        else $error("fill bit nonzero during shift");
    end
  end
endmodule

// File: rtl/shrot_lanes.sv
// One lane multiplexer per output bit choosing the lower or upper neighbour.
module shrot_lanes #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic             fill_lo,
  input  logic             fill_hi,
  input  logic             dir,
  output logic [WIDTH-1:0] y
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic from_lower;
    logic from_upper;

    if (i == 0) begin : g_lo_end
      assign from_lower = fill_lo;
    end else begin : g_lo_mid
      assign from_lower = a[i-1];
    end

    if (i == MSB) begin : g_hi_end
      assign from_upper = fill_hi;
    end else begin : g_hi_mid
      assign from_upper = a[i+1];
    end

    shrot_mux2 u_lane (.d0(from_lower), .d1(from_upper), .sel(dir), .y(y[i]));
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic             rot_sel,
  input  logic             dir_sel,
  output logic [WIDTH-1:0] y_out
);
  import shrot_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic  fill_lo;
  logic  fill_hi;
  move_e move;

  shrot_fill #(.WIDTH(WIDTH)) u_fill (
    .a       (a_in),
    .rot     (rot_sel),
    .fill_lo (fill_lo),
    .fill_hi (fill_hi)
  );

  shrot_lanes #(.WIDTH(WIDTH)) u_lanes (
    .a       (a_in),
    .fill_lo (fill_lo),
    .fill_hi (fill_hi),
    .dir     (dir_sel),
    .y       (y_out)
  );

  assign move = decode_move(rot_sel, dir_sel);

  always_comb begin
    case (move)
      MOVE_SHL: begin
        assert_shl_lsb_zero_R1: assert (y_out[0] == 1'b0)
          else $error("left shift LSB not zero");
        assert_shl_drop_R6: assert ($countones(y_out) == $countones(a_in) - int'(a_in[MSB]))
          else $error("left shift bit count wrong");
      end
      MOVE_SHR: begin
        assert_shr_msb_zero_R2: assert (y_out[MSB] == 1'b0)
          else $error("right shift MSB not zero");
        assert_shr_drop_R6: assert ($countones(y_out) == $countones(a_in) - int'(a_in[0]))
          else $error("right shift bit count wrong");
      end
      MOVE_ROL: begin
        assert_rol_wrap_R3: assert (y_out[0] == a_in[MSB])
          else $error("rotate left wrap bit wrong");
        assert_rol_count_R5: assert ($countones(y_out) == $countones(a_in))
          else $error("rotate left bit count changed");
      end
      default: begin
        assert_ror_wrap_R4: assert (y_out[MSB] == a_in[0])
          else $error("rotate right wrap bit wrong");
        assert_ror_count_R5: assert ($countones(y_out) == $countones(a_in))
          else $error("rotate right bit count changed");
      end
    endcase
  end
endmodule

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic         rot_sel = 1'b0;
  logic         dir_sel = 1'b0;
  logic [W-1:0] y_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shrot_unit #(.WIDTH(W)) dut (
    .a_in(a_in), .rot_sel(rot_sel), .dir_sel(dir_sel), .y_out(y_out)
  );

  function automatic logic [3:0] model(input logic [3:0] a, input logic r, input logic d);
    case ({r, d})
      2'b00:   return {a[2], a[1], a[0], 1'b0};
      2'b01:   return {1'b0, a[3], a[2], a[1]};
      2'b10:   return {a[2], a[1], a[0], a[3]};
      default: return {a[0], a[3], a[2], a[1]};
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%b rot=%b dir=%b actual=%b expected=%b",
               req, a_in, rot_sel, dir_sel, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic r, input logic d);
    @(negedge clk);
    a_in = a; rot_sel = r; dir_sel = d;
    #1;
  endtask

  task automatic test_zero_word;
    apply(4'b0000, 1'b0, 1'b0);
    check("R1 zero word", y_out, 4'b0000);
  endtask

  task automatic test_op(input string req, input logic r, input logic d);
    for (int v = 0; v < 16; v++) begin
      apply(4'(v), r, d);
      check(req, y_out, model(4'(v), r, d));
    end
  endtask

  task automatic test_popcount;
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 4; c++) begin
        int exp_cnt;
        apply(4'(v), c[1], c[0]);
        if (c[1]) exp_cnt = $countones(4'(v));
        else if (c[0]) exp_cnt = $countones(4'(v)) - int'(v[0]);
        else exp_cnt = $countones(4'(v)) - int'(v[3]);
        check(c[1] ? "R5 count" : "R6 count",
              4'($countones(y_out)), 4'(exp_cnt));
      end
    end
  endtask

  task automatic test_no_clock;
    @(negedge clk);
    a_in = 4'b1000; rot_sel = 1'b1; dir_sel = 1'b0;
    #1 check("R7 immediate", y_out, 4'b0001);
    a_in = 4'b0001; dir_sel = 1'b1;
    #1 check("R7 immediate", y_out, 4'b1000);
    rot_sel = 1'b0;
    #1 check("R7 immediate", y_out, 4'b0000);
    a_in = 4'b1011; dir_sel = 1'b0;
    #1 check("R7 immediate", y_out, 4'b0110);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    test_zero_word();
    test_op("R1 shl", 1'b0, 1'b0);
    test_op("R2 shr", 1'b0, 1'b1);
    test_op("R3 rol", 1'b1, 1'b0);
    test_op("R4 ror", 1'b1, 1'b1);
    apply(4'b1001, 1'b1, 1'b0); check("R3 corner", y_out, 4'b0011);
    apply(4'b1001, 1'b1, 1'b1); check("R4 corner", y_out, 4'b1100);
    apply(4'b1111, 1'b0, 1'b0); check("R1 corner", y_out, 4'b1110);
    apply(4'b1111, 1'b0, 1'b1); check("R2 corner", y_out, 4'b0111);
    test_popcount();
    test_no_clock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule